// File: doc/BRIEF.md
# Serial Audio Control Register Receiver

This block receives control frames for a two-channel car audio processor over a three-wire serial bus made of an enable line, a bit clock and a data line. The bus is much slower than the system clock. The receiver passes all three lines through a synchroniser and acts only on bit-clock rising edges it detects in the system clock domain. A frame starts with an 8-bit device address, sent while the enable line is low. The enable line then rises, and a 44-bit setting word follows. Both groups arrive least significant bit first.

When the enable line falls, the receiver checks the frame. A valid frame has the matching address, exactly 8 address bits and exactly 44 data bits, and no reserved test bit set. The receiver then decodes the word into per-channel settings and writes them into the left set, the right set or both. A two-bit target field in the word selects which. The settings drive the analog switch control of a volume, fader, tone and source-select path. One cycle after each commit, a single-cycle strobe pulses together with a flag for each channel that was written.

Top module: `sactl_rx`

## Requirements
- R1: After reset both channel sets hold volume code 0 (the minus-infinity setting), fade_off is 1, no source is selected, and every other field is 0. No strobe or flag pulses until a frame is accepted.
- R2: A frame is 8 address bits clocked while bus_ce is low, then 44 data bits clocked while bus_ce is high. Both groups are least significant bit first: the first bit received is bit 0. The frame is accepted only if the address bits, in arrival order, are 1,0,0,0,0,0,0,1 (value 8'h81).
- R3: Settings change only after bus_ce falls. upd_stb pulses for exactly one cycle, and the channel registers change in that same cycle. While bus_ce stays high, the outputs hold their values.
- R4: The target field is {D31,D30}. 01 writes the left set, 10 writes the right set and 11 writes both. 00 is the initial-setting code: it writes neither set and gives no strobe. upd_l and upd_r are high only together with upd_stb.
- R5: The volume code is D23..D16, with D16 as its LSB. Code 0 is minus infinity. At code 0, fade_off is 1 whatever the fader step. At any other code, fade_off is 0.
- R6: The input source code is {D32,D29,D28}. The one-hot output in_src decodes it as follows: 100 gives bit 0, 101 gives bit 1, 110 gives bit 2, 111 gives bit 3 and 000 gives bit 4. Any other code selects no source (all zero).
- R7: The output gain code is {D39,D35}. Codes 00 and 01 give out_gain 0 (0 dB), 10 gives 1 (+6.5 dB) and 11 gives 2 (+8.5 dB).
- R8: The remaining fields are taken as follows:
  - fade_step: D3..D0
  - bass_step: D7..D4
  - treb_step: D11..D8
  - in_gain: D15..D12
  - sbass_step: D27..D24
  - fade_front: D33 (1 means the front outputs are attenuated, 0 the rear)
  - in_mute: D34
- R9: If a frame that is otherwise valid has any of D36, D37, D38, D40, D41, D42 or D43 set, no set is written. test_flag pulses for one cycle instead.
- R10: If a frame does not have exactly 8 address bits and exactly 44 data bits, it is discarded without any update.
- R11: A frame whose address differs from 8'h81 is discarded without any update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce | input | 1 | Serial bus enable line |
| bus_clk | input | 1 | Serial bus bit clock |
| bus_dat | input | 1 | Serial bus data line |
| upd_stb | output | 1 | One-cycle commit strobe |
| upd_l | output | 1 | Left set written with this strobe |
| upd_r | output | 1 | Right set written with this strobe |
| test_flag | output | 1 | One-cycle pulse when a frame is rejected for test bits |
| vol_code | output | 2x8 | Volume code per channel (index 0 is left) |
| fade_step | output | 2x4 | Fader step per channel |
| fade_front | output | 2 | Fader attenuates the front outputs (1) or the rear outputs (0) |
| fade_off | output | 2 | Fader path muted because volume is minus infinity |
| bass_step | output | 2x4 | Bass step per channel |
| treb_step | output | 2x4 | Treble step per channel |
| sbass_step | output | 2x4 | Super-bass step per channel |
| in_gain | output | 2x4 | Input gain step per channel |
| in_src | output | 2x5 | One-hot input source per channel |
| out_gain | output | 2x2 | Output gain level per channel |
| in_mute | output | 2 | Input mute per channel |

## Verification
The hardest case is the boundary between a frame that is almost valid and one that is valid. These are frames with one bit too few or one bit too many, frames whose address differs in a single bit, and frames with only one high test bit. Each must leave every output untouched, and a valid frame sent next must still be accepted. The stimulus builds each of these frames bit by bit through a task that takes the address and data bit counts separately. It then reads back every field of both channels. A separate scenario holds the enable line high for a long time after the last data bit and confirms that nothing moves until the line falls.

// File: rtl/sactl_pkg.sv
package sactl_pkg;

  localparam int ADDR_BITS = 8;
  localparam int DATA_BITS = 44;
  localparam int NCH       = 2;
  localparam int SRC_N     = 5;
  localparam int VOL_W     = 8;
  localparam int STEP_W    = 4;
  localparam int OG_W      = 2;

  // field positions inside the data word
  localparam int P_FSTEP  = 0;
  localparam int P_BASS   = 4;
  localparam int P_TREB   = 8;
  localparam int P_IGAIN  = 12;
  localparam int P_VOL    = 16;
  localparam int P_SBASS  = 24;
  localparam int P_SRC0   = 28;
  localparam int P_SRC1   = 29;
  localparam int P_TGT    = 30;
  localparam int P_SRC2   = 32;
  localparam int P_FFRONT = 33;
  localparam int P_MUTE   = 34;
  localparam int P_OG0    = 35;
  localparam int P_OG1    = 39;

  localparam logic [DATA_BITS-1:0] TEST_MASK = 44'hF7000000000;

  typedef struct packed {
    logic [VOL_W-1:0]  vol;
    logic [STEP_W-1:0] fstep;
    logic              ffront;
    logic [STEP_W-1:0] bass;
    logic [STEP_W-1:0] treb;
    logic [STEP_W-1:0] igain;
    logic [STEP_W-1:0] sbass;
    logic [SRC_N-1:0]  src;
    logic [OG_W-1:0]   ogain;
    logic              mute;
  } chan_cfg_t;

  localparam chan_cfg_t CFG_RST = '0;

  function automatic chan_cfg_t decode_word(input logic [DATA_BITS-1:0] w);
    chan_cfg_t c;
    c.vol    = w[P_VOL +: VOL_W];
    c.fstep  = w[P_FSTEP +: STEP_W];
    c.ffront = w[P_FFRONT];
    c.bass   = w[P_BASS +: STEP_W];
    c.treb   = w[P_TREB +: STEP_W];
    c.igain  = w[P_IGAIN +: STEP_W];
    c.sbass  = w[P_SBASS +: STEP_W];
    c.mute   = w[P_MUTE];
    case ({w[P_SRC2], w[P_SRC1], w[P_SRC0]})
      3'b100:  c.src = 5'b00001;
      3'b101:  c.src = 5'b00010;
      3'b110:  c.src = 5'b00100;
      3'b111:  c.src = 5'b01000;
      3'b000:  c.src = 5'b10000;
      default: c.src = 5'b00000;
    endcase
    case ({w[P_OG1], w[P_OG0]})
      2'b10:   c.ogain = 2'd1;
      2'b11:   c.ogain = 2'd2;
      default: c.ogain = 2'd0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sactl_sync.sv
module sactl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_in,
  input  logic sck_in,
  input  logic dat_in,
  output logic ce_lvl,
  output logic ce_rise,
  output logic ce_fall,
  output logic sck_rise,
  output logic dat_lvl
);

  localparam int NL = 3;

  logic [NL-1:0] pin;
  logic [NL-1:0] sync_lvl;
  logic [1:0]    prev_q;

  assign pin = {dat_in, sck_in, ce_in};

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [NL-1:0] q;
    logic [NL-1:0] d;
    if (s == 0) begin : g_first
      assign d = pin;
    end else begin : g_next
      assign d = g_stg[s-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end

  assign sync_lvl = g_stg[STAGES-1].q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_lvl[1:0];
  end

  assign ce_lvl   = sync_lvl[0];
  assign ce_rise  =  sync_lvl[0] & ~prev_q[0];
  assign ce_fall  = ~sync_lvl[0] &  prev_q[0];
  assign sck_rise =  sync_lvl[1] & ~prev_q[1];
  assign dat_lvl  = sync_lvl[2];

endmodule

// File: rtl/sactl_shift.sv
module sactl_shift #(
  parameter int              AB   = 8,
  parameter int              DB   = 44,
  parameter logic [AB-1:0]   ADDR = 8'h81
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_lvl,
  input  logic          ce_rise,
  input  logic          ce_fall,
  input  logic          sck_rise,
  input  logic          dat,
  output logic          frm_end,
  output logic          frm_len_ok,
  output logic [DB-1:0] frm_word
);

  localparam int ACW = $clog2(AB + 1) + 1;
  localparam int DCW = $clog2(DB + 1) + 1;

  logic [AB-1:0]  asr_q,  asr_d;
  logic [ACW-1:0] acnt_q, acnt_d;
  logic           aok_q,  aok_d;
  logic [DB-1:0]  dsr_q,  dsr_d;
  logic [DCW-1:0] dcnt_q, dcnt_d;

  always_comb begin
    asr_d  = asr_q;
    acnt_d = acnt_q;
    aok_d  = aok_q;
    dsr_d  = dsr_q;
    dcnt_d = dcnt_q;
    if (ce_fall) begin
      acnt_d = '0;
      aok_d  = 1'b0;
    end else if (ce_rise) begin
      aok_d  = (acnt_q == ACW'(AB)) && (asr_q == ADDR);
      dcnt_d = '0;
    end else if (sck_rise) begin
      if (!ce_lvl) begin
        asr_d = {dat, asr_q[AB-1:1]};
        if (acnt_q != '1) acnt_d = acnt_q + 1'b1;
      end else begin
        dsr_d = {dat, dsr_q[DB-1:1]};
        if (dcnt_q != '1) dcnt_d = dcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asr_q  <= '0;
      acnt_q <= '0;
      aok_q  <= 1'b0;
      dsr_q  <= '0;
      dcnt_q <= '0;
    end else begin
      asr_q  <= asr_d;
      acnt_q <= acnt_d;
      aok_q  <= aok_d;
      dsr_q  <= dsr_d;
      dcnt_q <= dcnt_d;
    end
  end

  assign frm_end    = ce_fall;
  assign frm_len_ok = aok_q && (dcnt_q == DCW'(DB));
  assign frm_word   = dsr_q;

endmodule

// File: rtl/sactl_regs.sv
module sactl_regs
  import sactl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frm_end,
  input  logic                 frm_len_ok,
  input  logic [DATA_BITS-1:0] frm_word,
  output chan_cfg_t            cfg_o [NCH],
  output logic                 upd_stb,
  output logic [NCH-1:0]       upd_ch,
  output logic                 test_flag
);

  logic           test_hit;
  logic           accept;
  logic [NCH-1:0] wr_en;
  chan_cfg_t      cfg_new;
  chan_cfg_t      cfg_q [NCH];

  assign test_hit = |(frm_word & TEST_MASK);
  assign accept   = frm_end && frm_len_ok && !test_hit;
  assign wr_en    = {NCH{accept}} & frm_word[P_TGT +: NCH];
  assign cfg_new  = decode_word(frm_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) cfg_q[c] <= CFG_RST;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (wr_en[c]) cfg_q[c] <= cfg_new;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_stb   <= 1'b0;
      upd_ch    <= '0;
      test_flag <= 1'b0;
    end else begin
      upd_stb   <= |wr_en;
      upd_ch    <= wr_en;
      test_flag <= frm_end && frm_len_ok && test_hit;
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/sactl_rx.sv
module sactl_rx
  import sactl_pkg::*;
#(
  parameter int                     SYNC_STAGES = 2,
  parameter logic [ADDR_BITS-1:0]   DEV_ADDR    = 8'h81
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_ce,
  input  logic                          bus_clk,
  input  logic                          bus_dat,
  output logic                          upd_stb,
  output logic                          upd_l,
  output logic                          upd_r,
  output logic                          test_flag,
  output logic [NCH-1:0][VOL_W-1:0]     vol_code,
  output logic [NCH-1:0][STEP_W-1:0]    fade_step,
  output logic [NCH-1:0]                fade_front,
  output logic [NCH-1:0]                fade_off,
  output logic [NCH-1:0][STEP_W-1:0]    bass_step,
  output logic [NCH-1:0][STEP_W-1:0]    treb_step,
  output logic [NCH-1:0][STEP_W-1:0]    sbass_step,
  output logic [NCH-1:0][STEP_W-1:0]    in_gain,
  output logic [NCH-1:0][SRC_N-1:0]     in_src,
  output logic [NCH-1:0][OG_W-1:0]      out_gain,
  output logic [NCH-1:0]                in_mute
);

  logic [1:0]           rst_sq;
  logic                 rst_int_n;
  logic                 ce_lvl, ce_rise, ce_fall, sck_rise, dat_lvl;
  logic                 frm_end, frm_len_ok;
  logic [DATA_BITS-1:0] frm_word;
  logic [NCH-1:0]       upd_ch;
  chan_cfg_t            cfg [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_int_n = rst_sq[1];

  sactl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ce_in    (bus_ce),
    .sck_in   (bus_clk),
    .dat_in   (bus_dat),
    .ce_lvl   (ce_lvl),
    .ce_rise  (ce_rise),
    .ce_fall  (ce_fall),
    .sck_rise (sck_rise),
    .dat_lvl  (dat_lvl)
  );

  sactl_shift #(.AB(ADDR_BITS), .DB(DATA_BITS), .ADDR(DEV_ADDR)) u_shift (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ce_lvl     (ce_lvl),
    .ce_rise    (ce_rise),
    .ce_fall    (ce_fall),
    .sck_rise   (sck_rise),
    .dat        (dat_lvl),
    .frm_end    (frm_end),
    .frm_len_ok (frm_len_ok),
    .frm_word   (frm_word)
  );

  sactl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .frm_end    (frm_end),
    .frm_len_ok (frm_len_ok),
    .frm_word   (frm_word),
    .cfg_o      (cfg),
    .upd_stb    (upd_stb),
    .upd_ch     (upd_ch),
    .test_flag  (test_flag)
  );

  assign upd_l = upd_ch[0];
  assign upd_r = upd_ch[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign vol_code[c]   = cfg[c].vol;
    assign fade_step[c]  = cfg[c].fstep;
    assign fade_front[c] = cfg[c].ffront;
    assign fade_off[c]   = (cfg[c].vol == '0);
    assign bass_step[c]  = cfg[c].bass;
    assign treb_step[c]  = cfg[c].treb;
    assign sbass_step[c] = cfg[c].sbass;
    assign in_gain[c]    = cfg[c].igain;
    assign in_src[c]     = cfg[c].src;
    assign out_gain[c]   = cfg[c].ogain;
    assign in_mute[c]    = cfg[c].mute;
  end

endmodule

// File: rtl/sactl_rx_chk.sv
module sactl_rx_chk (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_stb,
  input logic             upd_l,
  input logic             upd_r,
  input logic             test_flag,
  input logic             ce_fall,
  input logic [1:0][7:0]  vol_code
);

  // R3: commit strobe lasts a single cycle
  a_r3_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);

  // R3: commit only follows a falling enable line
  a_r3_after_ce_fall: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> $past(ce_fall));

  // R3: volume codes hold between commits
  a_r3_hold_vol: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> $stable(vol_code));

  // R4: a strobe always names at least one channel
  a_r4_stb_target: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> (upd_l || upd_r));

  // R4: channel flags never stand alone
  a_r4_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> !(upd_l || upd_r));

  // R9: a rejected test frame never commits
  a_r9_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(test_flag && upd_stb));

endmodule

bind sactl_rx sactl_rx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_stb   (upd_stb),
  .upd_l     (upd_l),
  .upd_r     (upd_r),
  .test_flag (test_flag),
  .ce_fall   (ce_fall),
  .vol_code  (vol_code)
);

// File: tb/sactl_rx_bench.sv
module sactl_rx_bench;

  localparam int HB = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_ce = 1'b0, bus_clk = 1'b0, bus_dat = 1'b0;
  logic upd_stb, upd_l, upd_r, test_flag;
  logic [1:0][7:0] vol_code;
  logic [1:0][3:0] fade_step, bass_step, treb_step, sbass_step, in_gain;
  logic [1:0]      fade_front, fade_off, in_mute;
  logic [1:0][4:0] in_src;
  logic [1:0][1:0] out_gain;

  int checks = 0, errors = 0;
  int stb_cnt = 0, tf_cnt = 0;
  logic last_l = 1'b0, last_r = 1'b0;
  bit written [2];
  logic [43:0] exp_w [2];
  bit done = 0;

  always #10 clk = ~clk;

  sactl_rx u_sactl_rx (
    .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .bus_clk(bus_clk), .bus_dat(bus_dat),
    .upd_stb(upd_stb), .upd_l(upd_l), .upd_r(upd_r), .test_flag(test_flag),
    .vol_code(vol_code), .fade_step(fade_step), .fade_front(fade_front),
    .fade_off(fade_off), .bass_step(bass_step), .treb_step(treb_step),
    .sbass_step(sbass_step), .in_gain(in_gain), .in_src(in_src),
    .out_gain(out_gain), .in_mute(in_mute)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (upd_stb) begin
        stb_cnt++;
        last_l = upd_l;
        last_r = upd_r;
      end
      if (test_flag) tf_cnt++;
    end
  end

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [43:0] mk(input logic [1:0] tgt, input logic [7:0] vol,
      input logic [3:0] fs, input logic ff, input logic [3:0] bs, input logic [3:0] tr,
      input logic [3:0] ig, input logic [3:0] sb, input logic [2:0] src,
      input logic mu, input logic [1:0] og);
    logic [43:0] w = '0;
    w[3:0] = fs;  w[7:4] = bs;  w[11:8] = tr;  w[15:12] = ig;
    w[23:16] = vol; w[27:24] = sb;
    w[28] = src[0]; w[29] = src[1]; w[32] = src[2];
    w[31:30] = tgt; w[33] = ff; w[34] = mu;
    w[35] = og[0]; w[39] = og[1];
    return w;
  endfunction

  function automatic logic [4:0] exp_src(input logic [2:0] code);
    case (code)
      3'b100: return 5'b00001;
      3'b101: return 5'b00010;
      3'b110: return 5'b00100;
      3'b111: return 5'b01000;
      3'b000: return 5'b10000;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic logic [1:0] exp_og(input logic [1:0] code);
    case (code)
      2'b10: return 2'd1;
      2'b11: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  task automatic chk_ch(input string tag, input int c);
    logic [43:0] w = exp_w[c];
    if (!written[c]) begin
      chk(tag, "vol reset", vol_code[c], 0);
      chk(tag, "fade_off reset", fade_off[c], 1);
      chk(tag, "src reset", in_src[c], 0);
      chk(tag, "other reset", {fade_step[c], bass_step[c], treb_step[c], sbass_step[c],
          in_gain[c], out_gain[c], fade_front[c], in_mute[c]}, 0);
    end else begin
      chk(tag, "vol (R5)", vol_code[c], w[23:16]);
      chk(tag, "fade_off (R5)", fade_off[c], (w[23:16] == 8'h00));
      chk(tag, "fade_step (R8)", fade_step[c], w[3:0]);
      chk(tag, "bass (R8)", bass_step[c], w[7:4]);
      chk(tag, "treble (R8)", treb_step[c], w[11:8]);
      chk(tag, "in_gain (R8)", in_gain[c], w[15:12]);
      chk(tag, "sbass (R8)", sbass_step[c], w[27:24]);
      chk(tag, "fade_front (R8)", fade_front[c], w[33]);
      chk(tag, "mute (R8)", in_mute[c], w[34]);
      chk(tag, "src (R6)", in_src[c], exp_src({w[32], w[29], w[28]}));
      chk(tag, "out_gain (R7)", out_gain[c], exp_og({w[39], w[35]}));
    end
  endtask

  task automatic bus_bit(input logic b);
    bus_dat = b;
    repeat (HB) @(posedge clk);
    bus_clk = 1'b1;
    repeat (HB) @(posedge clk);
    bus_clk = 1'b0;
  endtask

  // shifts address and data, leaves the enable line high
  task automatic shift_frame(input logic [7:0] a, input int na, input logic [43:0] d, input int nd);
    for (int i = 0; i < na; i++) bus_bit(i < 8 ? a[i] : 1'b0);
    repeat (HB) @(posedge clk);
    bus_ce = 1'b1;
    repeat (HB) @(posedge clk);
    for (int i = 0; i < nd; i++) bus_bit(i < 44 ? d[i] : 1'b0);
    repeat (HB) @(posedge clk);
  endtask

  task automatic end_frame;
    bus_ce = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] a, input int na, input logic [43:0] d, input int nd);
    shift_frame(a, na, d, nd);
    end_frame();
  endtask

  // writes expectation when a valid frame targets channels
  task automatic expect_write(input logic [43:0] d);
    for (int c = 0; c < 2; c++) begin
      if (d[30 + c]) begin
        written[c] = 1'b1;
        exp_w[c] = d;
      end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk_ch("R1", 0);
    chk_ch("R1", 1);
    chk("R1", "strobes", stb_cnt + tf_cnt, 0);
  endtask

  task automatic t_left;
    logic [43:0] d = mk(2'b01, 8'h5A, 4'd9, 1'b1, 4'd3, 4'd12, 4'd7, 4'd10, 3'b100, 1'b1, 2'b10);
    int s0 = stb_cnt;
    send(8'h81, 8, d, 44);
    expect_write(d);
    chk("R2", "stb count", stb_cnt, s0 + 1);
    chk("R4", "left flag", {last_l, last_r}, 2'b10);
    chk_ch("R2", 0);
    chk_ch("R4", 1);
  endtask

  task automatic t_right;
    logic [43:0] d = mk(2'b10, 8'h33, 4'd2, 1'b0, 4'd15, 4'd1, 4'd0, 4'd5, 3'b000, 1'b0, 2'b11);
    int s0 = stb_cnt;
    send(8'h81, 8, d, 44);
    expect_write(d);
    chk("R4", "stb count", stb_cnt, s0 + 1);
    chk("R4", "right flag", {last_l, last_r}, 2'b01);
    chk_ch("R4", 0);
    chk_ch("R4", 1);
  endtask

  task automatic t_both_mute;
    logic [43:0] d = mk(2'b11, 8'h00, 4'd5, 1'b1, 4'd6, 4'd7, 4'd8, 4'd9, 3'b111, 1'b1, 2'b01);
    int s0 = stb_cnt;
    send(8'h81, 8, d, 44);
    expect_write(d);
    chk("R4", "stb count", stb_cnt, s0 + 1);
    chk("R4", "both flags", {last_l, last_r}, 2'b11);
    chk("R5", "fade_off both", fade_off, 2'b11);
    chk_ch("R5", 0);
    chk_ch("R5", 1);
  endtask

  task automatic t_init_code;
    logic [43:0] d = mk(2'b00, 8'h7F, 4'd1, 1'b0, 4'd1, 4'd1, 4'd1, 4'd1, 3'b101, 1'b0, 2'b11);
    int s0 = stb_cnt;
    send(8'h81, 8, d, 44);
    chk("R4", "no stb on init code", stb_cnt, s0);
    chk_ch("R4", 0);
    chk_ch("R4", 1);
  endtask

  task automatic t_sources;
    logic [2:0] codes [5] = '{3'b101, 3'b110, 3'b001, 3'b011, 3'b010};
    for (int k = 0; k < 5; k++) begin
      logic [43:0] d = mk(2'b01, 8'h10 + 8'(k), 4'd0, 1'b0, 4'd0, 4'd0, 4'(k), 4'd0,
                          codes[k], 1'b0, 2'b00);
      send(8'h81, 8, d, 44);
      expect_write(d);
      chk("R6", "src code", in_src[0], exp_src(codes[k]));
      chk("R7", "og 00", out_gain[0], 0);
    end
  endtask

  task automatic t_commit_timing;
    logic [43:0] d = mk(2'b01, 8'hC4, 4'd11, 1'b1, 4'd2, 4'd4, 4'd6, 4'd8, 3'b110, 1'b1, 2'b11);
    int s0 = stb_cnt;
    logic [7:0] v0 = vol_code[0];
    shift_frame(8'h81, 8, d, 44);
    repeat (200) @(posedge clk);
    @(negedge clk);
    chk("R3", "vol before fall", vol_code[0], v0);
    chk("R3", "no stb before fall", stb_cnt, s0);
    end_frame();
    expect_write(d);
    chk("R3", "stb after fall", stb_cnt, s0 + 1);
    chk_ch("R3", 0);
  endtask

  task automatic t_bad_addr;
    logic [43:0] d = mk(2'b11, 8'h99, 4'd3, 1'b0, 4'd3, 4'd3, 4'd3, 4'd3, 3'b100, 1'b0, 2'b10);
    int s0 = stb_cnt;
    send(8'h80, 8, d, 44);
    send(8'h01, 8, d, 44);
    send(8'h83, 8, d, 44);
    chk("R11", "no stb", stb_cnt, s0);
    chk_ch("R11", 0);
    chk_ch("R11", 1);
  endtask

  task automatic t_test_bits;
    logic [43:0] d = mk(2'b11, 8'h44, 4'd4, 1'b0, 4'd4, 4'd4, 4'd4, 4'd4, 3'b111, 1'b0, 2'b10);
    int s0 = stb_cnt;
    int t0 = tf_cnt;
    logic [43:0] d1 = d;
    logic [43:0] d2 = d;
    d1[36] = 1'b1;
    d2[43] = 1'b1;
    send(8'h81, 8, d1, 44);
    chk("R9", "flag d36", tf_cnt, t0 + 1);
    send(8'h81, 8, d2, 44);
    chk("R9", "flag d43", tf_cnt, t0 + 2);
    chk("R9", "no stb", stb_cnt, s0);
    chk_ch("R9", 0);
    chk_ch("R9", 1);
  endtask

  task automatic t_length;
    logic [43:0] d = mk(2'b11, 8'h66, 4'd6, 1'b1, 4'd6, 4'd6, 4'd6, 4'd6, 3'b101, 1'b1, 2'b11);
    int s0 = stb_cnt;
    send(8'h81, 8, d, 43);
    send(8'h81, 8, d, 45);
    send(8'h81, 7, d, 44);
    send(8'h81, 9, d, 44);
    chk("R10", "no stb on bad length", stb_cnt, s0);
    chk_ch("R10", 0);
    chk_ch("R10", 1);
    send(8'h81, 8, d, 44);
    expect_write(d);
    chk("R10", "good frame after bad", stb_cnt, s0 + 1);
    chk_ch("R10", 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    written[0] = 0; written[1] = 0;
    exp_w[0] = '0; exp_w[1] = '0;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (10) @(posedge clk);
    t_reset();
    t_left();
    t_right();
    t_init_code();
    t_both_mute();
    t_sources();
    t_commit_timing();
    t_bad_addr();
    t_test_bits();
    t_length();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule